// File: doc/BRIEF.md
# Shared-Target Crossbar Allocator

This block links a set of requesters (processor ports first, then I/O-control ports) to a set of shared memory targets through a crosspoint switch. Each requester presents a request flag, the index of the target it wants, and a priority level. The requests that are still waiting are compared in three matrices: a conflict matrix marks every pair that wants the same target, a priority matrix orders every pair, and a queue matrix is their bitwise AND. A requester whose queue row is empty, and whose target is neither held by another requester nor flagged busy from outside, closes its crosspoint.

A closed crosspoint stays closed for as long as its owner keeps requesting. When the owner withdraws, the target is free one cycle later. Waiters are re-ranked every cycle, so a high-priority request that arrives late is served before a lower-priority one that has waited longer. Different targets are served in parallel. For every target the block outputs the index of the connected requester, and it routes that requester's write word to the target.

Top module: `xbar_alloc`

## Requirements
- R1: After reset, all grant, waiting and crosspoint-valid bits are 0 and every target data word is 0.
- R2: A request to a free, non-busy target with no rival is granted at the first rising edge after it is presented. From then on the target's crosspoint select carries the requester's index (requester i is index i: processor ports 0..N_CPU-1, then I/O ports).
- R3: A granted requester keeps its grant for as long as its request stays high, whatever other requesters do.
- R4: When the owner drops its request, its grant and the target's crosspoint-valid clear at the next edge. A waiting requester for that target is granted at the edge after that.
- R5: Among requesters contending for a free target, the one with the numerically largest priority value wins.
- R6: On equal priority, the lower requester index wins.
- R7: Priority is pre-emptive among waiters. A higher-priority request that arrives after a lower-priority one is already waiting is granted first when the target frees.
- R8: While a target's external busy input is high, no new crosspoint to it closes and its requesters keep waiting. The grant follows at the first edge after busy falls.
- R9: Requests for distinct targets are granted in the same cycle.
- R10: `waiting[i]` is 1, with the same registered timing as `grant`, exactly when requester i has its request up and holds no grant.
- R11: No target is connected to two requesters, and no requester holds more than one target.
- R12: Each target's data word equals the write word of its connected requester, and is 0 when no crosspoint is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request flag per requester |
| req_target | input | N_REQ*TW | Target index per requester, 4 bits each by default |
| req_prio | input | N_REQ*PW | Priority per requester, larger wins |
| req_wdata | input | N_REQ*DW | Write word per requester |
| tgt_busy | input | N_MEM | External busy flag per target |
| grant | output | N_REQ | Registered grant per requester |
| waiting | output | N_REQ | Registered waiting indication per requester |
| xp_valid | output | N_MEM | Crosspoint closed per target |
| xp_sel | output | N_MEM*RW | Connected requester index per target |
| tgt_wdata | output | N_MEM*DW | Routed write word per target |

## Verification
Several properties are checked on every cycle. A held grant persists, a dropped request loses its grant, a busy target never gains an owner, grant and waiting never overlap, the pair ordering is a strict total order, at most one winner appears per target, and no requester owns two targets. Which requester actually wins, and in which cycle, can only be shown by the directed scenarios: priority order, index tie-break, late-arrival overtaking, the two-edge hand-over after a release, and parallel grants to separate targets. The routed data words are also checked only in those scenarios.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // True when requester a (level pa, index ia) is ranked above b.
    function automatic logic outranks(input int unsigned pa, input int unsigned pb,
                                      input int unsigned ia, input int unsigned ib);
        return (pa > pb) || ((pa == pb) && (ia < ib));
    endfunction

endpackage

// File: rtl/xbar_conflict_mtx.sv
module xbar_conflict_mtx #(
    parameter int N_REQ = 14,
    parameter int TW    = 4
) (
    input  logic [N_REQ-1:0]              active,
    input  logic [N_REQ*TW-1:0]           tgt,
    output logic [N_REQ-1:0][N_REQ-1:0]   cmx
);

    for (genvar i = 0; i < N_REQ; i++) begin : g_row
        for (genvar j = 0; j < N_REQ; j++) begin : g_col
            if (i == j) begin : g_diag
                assign cmx[i][j] = 1'b0;
            end else begin : g_off
                assign cmx[i][j] = active[i] && active[j] &&
                                   (tgt[i*TW +: TW] == tgt[j*TW +: TW]);
            end
        end
    end

endmodule

// File: rtl/xbar_prio_mtx.sv
module xbar_prio_mtx
    import xbar_pkg::*;
#(
    parameter int N_REQ = 14,
    parameter int PW    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REQ*PW-1:0]           prio,
    output logic [N_REQ-1:0][N_REQ-1:0]   pmx
);

    // pmx[i][j] = 1 when requester i ranks above requester j
    for (genvar i = 0; i < N_REQ; i++) begin : g_row
        for (genvar j = 0; j < N_REQ; j++) begin : g_col
            if (i == j) begin : g_diag
                assign pmx[i][j] = 1'b0;
            end else begin : g_off
                assign pmx[i][j] = outranks(int'(prio[i*PW +: PW]), int'(prio[j*PW +: PW]),
                                            i, j);
            end
            if (i < j) begin : g_chk
                AST_TOTAL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                    pmx[i][j] != pmx[j][i]); // R6
            end
        end
    end

endmodule

// File: rtl/xbar_queue_ctl.sv
module xbar_queue_ctl #(
    parameter int N_REQ = 14,
    parameter int N_MEM = 16,
    parameter int TW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REQ-1:0]              active,
    input  logic [N_REQ*TW-1:0]           tgt,
    input  logic [N_REQ-1:0][N_REQ-1:0]   cmx,
    input  logic [N_REQ-1:0][N_REQ-1:0]   pmx,
    input  logic [N_MEM-1:0]              tgt_free,
    output logic [N_REQ-1:0]              win
);

    // qmx[i][j] = 1: requester i stands in line behind requester j
    logic [N_REQ-1:0][N_REQ-1:0] qmx;
    logic [N_REQ-1:0]            free_of;

    for (genvar i = 0; i < N_REQ; i++) begin : g_q
        for (genvar j = 0; j < N_REQ; j++) begin : g_qc
            assign qmx[i][j] = cmx[i][j] & pmx[j][i];
        end

        always_comb begin
            free_of[i] = 1'b0;
            for (int t = 0; t < N_MEM; t++) begin
                if (tgt[i*TW +: TW] == TW'(t)) free_of[i] = tgt_free[t];
            end
        end

        assign win[i] = active[i] && !(|qmx[i]) && free_of[i];
    end

    // At most one winner per target in any cycle
    for (genvar t = 0; t < N_MEM; t++) begin : g_wchk
        logic [N_REQ-1:0] aim;
        for (genvar i = 0; i < N_REQ; i++) begin : g_aim
            assign aim[i] = (tgt[i*TW +: TW] == TW'(t));
        end
        AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(win & aim) <= 1); // R11
    end

endmodule

// File: rtl/xbar_xpoint_state.sv
module xbar_xpoint_state #(
    parameter int N_REQ = 14,
    parameter int N_MEM = 16,
    parameter int TW    = 4,
    parameter int RW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REQ-1:0]              req_valid,
    input  logic [N_REQ*TW-1:0]           tgt,
    input  logic [N_MEM-1:0]              tgt_busy,
    input  logic [N_REQ-1:0]              win,
    output logic [N_MEM-1:0]              tgt_free,
    output logic [N_REQ-1:0]              grant_q,
    output logic [N_REQ-1:0]              wait_q,
    output logic [N_MEM-1:0]              own_vld_q,
    output logic [N_MEM-1:0][RW-1:0]      own_q
);

    typedef struct packed {
        logic [N_MEM-1:0]         own_vld;
        logic [N_MEM-1:0][RW-1:0] own;
        logic [N_REQ-1:0]         grant;
        logic [N_REQ-1:0]         wait_r;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        for (int t = 0; t < N_MEM; t++) begin
            if (cur_q.own_vld[t]) begin
                // release when the owner withdraws; target free next cycle
                for (int i = 0; i < N_REQ; i++) begin
                    if (cur_q.own[t] == RW'(i) && !req_valid[i]) nxt_d.own_vld[t] = 1'b0;
                end
            end else begin
                for (int i = 0; i < N_REQ; i++) begin
                    if (win[i] && tgt[i*TW +: TW] == TW'(t)) begin
                        nxt_d.own_vld[t] = 1'b1;
                        nxt_d.own[t]     = RW'(i);
                    end
                end
            end
        end
        nxt_d.grant = '0;
        for (int i = 0; i < N_REQ; i++) begin
            for (int t = 0; t < N_MEM; t++) begin
                if (nxt_d.own_vld[t] && nxt_d.own[t] == RW'(i)) nxt_d.grant[i] = 1'b1;
            end
        end
        nxt_d.wait_r = req_valid & ~nxt_d.grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tgt_free  = ~cur_q.own_vld & ~tgt_busy;
    assign grant_q   = cur_q.grant;
    assign wait_q    = cur_q.wait_r;
    assign own_vld_q = cur_q.own_vld;
    assign own_q     = cur_q.own;

    for (genvar i = 0; i < N_REQ; i++) begin : g_rchk
        logic [N_MEM-1:0] seats;
        for (genvar t = 0; t < N_MEM; t++) begin : g_seat
            assign seats[t] = own_vld_q[t] && (own_q[t] == RW'(i));
        end
        AST_SINGLE_SEAT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(seats) <= 1); // R11
        AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            grant_q[i] && req_valid[i] |=> grant_q[i]); // R3
        AST_DROP_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] |=> !grant_q[i]); // R4
    end

    for (genvar t = 0; t < N_MEM; t++) begin : g_tchk
        AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            !own_vld_q[t] && tgt_busy[t] |=> !own_vld_q[t]); // R8
    end

    AST_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q & wait_q) == '0); // R10

endmodule

// File: rtl/xbar_xpoint_mux.sv
module xbar_xpoint_mux #(
    parameter int N_REQ = 14,
    parameter int N_MEM = 16,
    parameter int RW    = 4,
    parameter int DW    = 8
) (
    input  logic [N_REQ*DW-1:0]           req_wdata,
    input  logic [N_MEM-1:0]              own_vld,
    input  logic [N_MEM-1:0][RW-1:0]      own,
    output logic [N_MEM*DW-1:0]           tgt_wdata
);

    for (genvar t = 0; t < N_MEM; t++) begin : g_tgt
        always_comb begin
            tgt_wdata[t*DW +: DW] = '0;
            for (int i = 0; i < N_REQ; i++) begin
                if (own_vld[t] && own[t] == RW'(i)) tgt_wdata[t*DW +: DW] = req_wdata[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc #(
    parameter int N_CPU = 4,
    parameter int N_IO  = 10,
    parameter int N_MEM = 16,
    parameter int PW    = 3,
    parameter int DW    = 8,
    localparam int N_REQ = N_CPU + N_IO,
    localparam int TW    = (N_MEM > 1) ? $clog2(N_MEM) : 1,
    localparam int RW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_REQ-1:0]      req_valid,
    input  logic [N_REQ*TW-1:0]   req_target,
    input  logic [N_REQ*PW-1:0]   req_prio,
    input  logic [N_REQ*DW-1:0]   req_wdata,
    input  logic [N_MEM-1:0]      tgt_busy,
    output logic [N_REQ-1:0]      grant,
    output logic [N_REQ-1:0]      waiting,
    output logic [N_MEM-1:0]      xp_valid,
    output logic [N_MEM*RW-1:0]   xp_sel,
    output logic [N_MEM*DW-1:0]   tgt_wdata
);

    logic [N_REQ-1:0][N_REQ-1:0] cmx;
    logic [N_REQ-1:0][N_REQ-1:0] pmx;
    logic [N_REQ-1:0]            active;
    logic [N_REQ-1:0]            win;
    logic [N_MEM-1:0]            tgt_free;
    logic [N_REQ-1:0]            grant_q;
    logic [N_REQ-1:0]            wait_q;
    logic [N_MEM-1:0]            own_vld_q;
    logic [N_MEM-1:0][RW-1:0]    own_q;

    // only requesters without a crosspoint take part in arbitration
    assign active = req_valid & ~grant_q;

    xbar_conflict_mtx #(.N_REQ(N_REQ), .TW(TW)) u_cmx (
        .active (active),
        .tgt    (req_target),
        .cmx    (cmx)
    );

    xbar_prio_mtx #(.N_REQ(N_REQ), .PW(PW)) u_pmx (
        .clk    (clk),
        .rst_n  (rst_n),
        .prio   (req_prio),
        .pmx    (pmx)
    );

    xbar_queue_ctl #(.N_REQ(N_REQ), .N_MEM(N_MEM), .TW(TW)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tgt      (req_target),
        .cmx      (cmx),
        .pmx      (pmx),
        .tgt_free (tgt_free),
        .win      (win)
    );

    xbar_xpoint_state #(.N_REQ(N_REQ), .N_MEM(N_MEM), .TW(TW), .RW(RW)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .tgt       (req_target),
        .tgt_busy  (tgt_busy),
        .win       (win),
        .tgt_free  (tgt_free),
        .grant_q   (grant_q),
        .wait_q    (wait_q),
        .own_vld_q (own_vld_q),
        .own_q     (own_q)
    );

    xbar_xpoint_mux #(.N_REQ(N_REQ), .N_MEM(N_MEM), .RW(RW), .DW(DW)) u_mux (
        .req_wdata (req_wdata),
        .own_vld   (own_vld_q),
        .own       (own_q),
        .tgt_wdata (tgt_wdata)
    );

    assign grant    = grant_q;
    assign waiting  = wait_q;
    assign xp_valid = own_vld_q;
    assign xp_sel   = own_q;

endmodule

// File: tb/sim_xbar_alloc.sv
module sim_xbar_alloc;

    localparam int NR = 14;
    localparam int NM = 16;
    localparam int TW = 4;
    localparam int RW = 4;
    localparam int PW = 3;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     req_valid = '0;
    logic [NR*TW-1:0]  req_target = '0;
    logic [NR*PW-1:0]  req_prio = '0;
    logic [NR*DW-1:0]  req_wdata = '0;
    logic [NM-1:0]     tgt_busy = '0;
    logic [NR-1:0]     grant;
    logic [NR-1:0]     waiting;
    logic [NM-1:0]     xp_valid;
    logic [NM*RW-1:0]  xp_sel;
    logic [NM*DW-1:0]  tgt_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    xbar_alloc u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_prio(req_prio), .req_wdata(req_wdata), .tgt_busy(tgt_busy),
        .grant(grant), .waiting(waiting), .xp_valid(xp_valid), .xp_sel(xp_sel),
        .tgt_wdata(tgt_wdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_req(input int i, input int t, input int p);
        req_valid[i] = 1'b1;
        req_target[i*TW +: TW] = TW'(t);
        req_prio[i*PW +: PW] = PW'(p);
    endtask

    task automatic clr_all();
        req_valid = '0;
        tgt_busy = '0;
        step(2);
    endtask

    // R11: per-cycle exclusivity seen at the ports
    task automatic check_excl(input string tag);
        logic [NR-1:0] seen;
        bit dup;
        seen = '0;
        dup = 0;
        for (int t = 0; t < NM; t++) begin
            if (xp_valid[t]) begin
                if (seen[xp_sel[t*RW +: RW]]) dup = 1;
                seen[xp_sel[t*RW +: RW]] = 1'b1;
            end
        end
        check({"R11 ", tag, " no requester on two targets"}, 64'(dup), 64'd0);
        check({"R11 ", tag, " grant matches crosspoint owners"}, 64'(seen), 64'(grant));
    endtask

    task automatic t_reset();
        check("R1 grant after reset", 64'(grant), 64'd0);
        check("R1 waiting after reset", 64'(waiting), 64'd0);
        check("R1 xp_valid after reset", 64'(xp_valid), 64'd0);
        check("R1 tgt_wdata after reset", 64'(|tgt_wdata), 64'd0);
    endtask

    task automatic t_single();
        set_req(0, 3, 1);
        step(1);
        check("R2 single grant", 64'(grant), 64'h1);
        check("R2 xp_valid target 3", 64'(xp_valid[3]), 64'd1);
        check("R2 xp_sel target 3", 64'(xp_sel[3*RW +: RW]), 64'd0);
        check("R10 granted not waiting", 64'(waiting), 64'd0);
        check("R12 routed data target 3", 64'(tgt_wdata[3*DW +: DW]), 64'h10);
        check_excl("single");
        req_valid[0] = 1'b0;
        step(1);
        check("R4 grant drops after release", 64'(grant), 64'd0);
        check("R4 crosspoint opens after release", 64'(xp_valid[3]), 64'd0);
        check("R12 idle target data zero", 64'(tgt_wdata[3*DW +: DW]), 64'd0);
        clr_all();
    endtask

    task automatic t_contend();
        set_req(2, 5, 2);
        set_req(6, 5, 6);
        set_req(9, 5, 4);
        step(1);
        check("R5 highest priority wins", 64'(grant), 64'(1 << 6));
        check("R10 losers waiting", 64'(waiting), 64'((1 << 2) | (1 << 9)));
        check("R5 xp_sel target 5", 64'(xp_sel[5*RW +: RW]), 64'd6);
        step(3);
        check("R3 grant held while requesting", 64'(grant), 64'(1 << 6));
        check_excl("contend");
        req_valid[6] = 1'b0;
        step(1);
        check("R4 no grant on release edge", 64'(grant), 64'd0);
        check("R4 waiters still waiting", 64'(waiting), 64'((1 << 2) | (1 << 9)));
        step(1);
        check("R4 R5 next waiter granted", 64'(grant), 64'(1 << 9));
        check("R12 routed data target 5", 64'(tgt_wdata[5*DW +: DW]), 64'h19);
        clr_all();
    endtask

    task automatic t_tie();
        set_req(11, 7, 3);
        set_req(4, 7, 3);
        step(1);
        check("R6 lower index wins tie", 64'(grant), 64'(1 << 4));
        check("R6 loser waits", 64'(waiting), 64'(1 << 11));
        clr_all();
    endtask

    task automatic t_preempt();
        set_req(1, 8, 1);
        step(1);
        set_req(3, 8, 2);
        step(2);
        check("R7 early waiter queued", 64'(waiting), 64'(1 << 3));
        set_req(12, 8, 7);
        step(1);
        req_valid[1] = 1'b0;
        step(2);
        check("R7 late high priority served first", 64'(grant), 64'(1 << 12));
        check("R7 earlier low priority still waits", 64'(waiting), 64'(1 << 3));
        check_excl("preempt");
        clr_all();
    endtask

    task automatic t_busy();
        tgt_busy[10] = 1'b1;
        set_req(5, 10, 7);
        step(3);
        check("R8 no grant to busy target", 64'(grant), 64'd0);
        check("R8 requester waits on busy", 64'(waiting), 64'(1 << 5));
        check("R8 crosspoint stays open", 64'(xp_valid[10]), 64'd0);
        tgt_busy[10] = 1'b0;
        step(1);
        check("R8 grant after busy falls", 64'(grant), 64'(1 << 5));
        clr_all();
    endtask

    task automatic t_parallel();
        set_req(0, 1, 0);
        set_req(7, 2, 0);
        set_req(13, 15, 0);
        step(1);
        check("R9 parallel grants", 64'(grant), 64'((1 << 0) | (1 << 7) | (1 << 13)));
        check("R9 xp_sel target 2", 64'(xp_sel[2*RW +: RW]), 64'd7);
        check("R9 xp_sel target 15", 64'(xp_sel[15*RW +: RW]), 64'd13);
        check("R12 routed data target 15", 64'(tgt_wdata[15*DW +: DW]), 64'h1D);
        check_excl("parallel");
        clr_all();
    endtask

    initial begin
        for (int i = 0; i < NR; i++) req_wdata[i*DW +: DW] = DW'(8'h10 + i);
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_single();
        t_contend();
        t_tie();
        t_preempt();
        t_busy();
        t_parallel();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule